// File: doc/BRIEF.md
# Acquisition Channel Select Sequencer

This block turns a serial control word into the per-conversion switch, hold and gain controls for a three-channel front end that samples all channels at once. The word is shifted in MSB first, one bit per enabled clock, and a load strobe latches it. Two fields are taken from the latched word: a 2-bit gain code and a 3-bit input-select code. Each convert command then decodes them into a source selection and a gain for each converter path, sample strobes for the primary holds, strobes for the two deferred holds on channels 1 and 2, and the select of the mux that feeds the two asynchronous holds.

Part of the decode depends on earlier conversions. Some select codes leave the asynchronous mux where it was. One code converts values that an earlier code captured in the deferred holds. The asynchronous route is only meaningful if the asynchronous hold strobe fell before the convert command. The block tracks this state and raises a per-channel undefined-result flag whenever a conversion result would be undefined. The analog switches, amplifiers and converters are outside the block and are seen only through these outputs.

Top module: `acqSelectSeq`

## Requirements
- R1: While `shiftEn` is high, each clock shifts `serIn` into the word MSB first, so a 16-bit word needs 16 shifts. `loadStb` latches the shifted word. The gain code is taken from word bits 9:8 and the select code from bits 12:10. All other bits have no effect on any output.
- R2: After reset, every output is 0 and the asynchronous mux select is 0 (open). No deferred hold counts as captured, so a select-3 conversion right after reset flags channels 1 and 2 as undefined.
- R3: Source encoding on `chNSrc`: 0 none, 1 input 1, 2 input 2, 3 input 3 direct or through the primary hold, 4 input 3 from the deferred hold, 5 asynchronous hold, 6 input 4. Select 7 drives source 1 on all three channels and strobes all three primary holds (`syncSampleStb` = 3'b111).
- R4: Selects 4, 5 and 6 drive source 2 on all channels. They strobe all three primary holds and both deferred holds (`deferStb` = 2'b11), and mark both deferred holds as captured.
- R5: `asyncMuxSel` (0 open, 1 input 3, 2 input 2) becomes 0 on select 4, 1 on select 5 and 2 on select 6. Every other select, a load without a convert, and clocks without a convert leave it unchanged.
- R6: Select 3 drives source 4 on channels 1 and 2 and source 3 on channel 3, and strobes only the channel-3 primary hold. Channel N (N = 1, 2) is flagged undefined (`undefFlag` bit N-1) unless its deferred hold was captured by an earlier conversion.
- R7: Select 2 drives source 3 on all channels, strobes all primary holds, and strobes only the channel-1 deferred hold (`deferStb` = 2'b01). This marks only that hold as captured.
- R8: Select 1 drives source 5 on channels 1 and 2 and source 6 on channel 3. Channels 1 and 2 are flagged undefined if the asynchronous mux is open, or if `asyncHoldN` did not fall after the previous convert and before the clock edge of this convert. A fall on the same edge as a convert counts toward the next convert.
- R9: Select 0 drives source 0 on channels 1 and 2 and source 6 on channel 3, with `undefFlag` = 3'b011. Channel 3 is never flagged undefined.
- R10: `gainCh1` and `gainCh2` take the latched gain code on every convert. `gainCh3` takes it only on select 7 and is 3 (unity) for every other select.
- R11: Outputs change on the clock edge that samples `convStart`. `convDone` and the strobes are high for exactly that one following cycle. Sources, gains and flags hold until the next convert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial control data, MSB first |
| shiftEn | input | 1 | Shift one bit this clock |
| loadStb | input | 1 | Latch the shifted word |
| convStart | input | 1 | Convert command |
| asyncHoldN | input | 1 | Asynchronous hold strobe, active low |
| convDone | output | 1 | One-cycle marker of a decoded conversion |
| ch1Src | output | 3 | Channel 1 source select |
| ch2Src | output | 3 | Channel 2 source select |
| ch3Src | output | 3 | Channel 3 source select |
| gainCh1 | output | 2 | Channel 1 gain code |
| gainCh2 | output | 2 | Channel 2 gain code |
| gainCh3 | output | 2 | Channel 3 gain code |
| syncSampleStb | output | 3 | Primary hold sample strobes, bit 0 = channel 1 |
| deferStb | output | 2 | Deferred hold strobes, bit 0 = channel 1 |
| asyncMuxSel | output | 2 | Asynchronous hold mux select |
| undefFlag | output | 3 | Undefined-result flag per channel |

## Verification
The interesting collision is a fall of the asynchronous hold strobe on the same clock edge as a convert. The bench provokes it by pulling `asyncHoldN` low together with `convStart`. It then expects a select-1 conversion at that edge to be flagged undefined, and the next select-1 convert with no new fall to be valid. Randomly chosen conversions mix three cases: no fall, a fall strictly before the convert, and a same-edge fall. Each case is judged against a model of the mux and the captured-hold state that the bench keeps for itself.

// File: rtl/acqSeqPkg.sv
package acqSeqPkg;

  typedef enum logic [2:0] {
    SRC_NONE      = 3'd0,
    SRC_IN1       = 3'd1,
    SRC_IN2       = 3'd2,
    SRC_IN3       = 3'd3,
    SRC_IN3_DEFER = 3'd4,
    SRC_ASYNC     = 3'd5,
    SRC_IN4       = 3'd6
  } srcSel_e;

  typedef enum logic [1:0] {
    AMUX_OPEN = 2'd0,
    AMUX_IN3  = 2'd1,
    AMUX_IN2  = 2'd2
  } asyncMux_e;

  localparam int GAIN_W = 2;
  localparam int SEL_W  = 3;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = 2'd3;

  // Strobes and fields handed from control to datapath each cycle
  typedef struct packed {
    logic              conv;
    logic              asyncBefore;
    logic [GAIN_W-1:0] gain;
    logic [SEL_W-1:0]  code;
  } ctrlStb_t;

endpackage

// File: rtl/acqSeqCtrl.sv
module acqSeqCtrl
  import acqSeqPkg::*;
#(
  parameter int GAIN_LSB = 8,
  parameter int SEL_LSB  = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serIn,
  input  logic     shiftEn,
  input  logic     loadStb,
  input  logic     convStart,
  input  logic     asyncHoldN,
  output ctrlStb_t stb
);

  // Bits above the select field only pass through and fall off the top
  localparam int KEEP_W = SEL_LSB + SEL_W;

  logic [KEEP_W-1:0] shiftReg;
  logic [GAIN_W-1:0] gainReg;
  logic [SEL_W-1:0]  codeReg;
  logic              asyncPrevN;
  logic              asyncSeen;
  logic              asyncFall;

  assign asyncFall = asyncPrevN & ~asyncHoldN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      gainReg    <= '0;
      codeReg    <= '0;
      asyncPrevN <= 1'b1;
      asyncSeen  <= 1'b0;
    end else begin
      if (shiftEn) shiftReg <= {shiftReg[KEEP_W-2:0], serIn};
      if (loadStb) begin
        gainReg <= shiftReg[GAIN_LSB +: GAIN_W];
        codeReg <= shiftReg[SEL_LSB +: SEL_W];
      end
      asyncPrevN <= asyncHoldN;
      // a fall on the convert edge is kept for the following convert
      if (asyncFall)      asyncSeen <= 1'b1;
      else if (convStart) asyncSeen <= 1'b0;
    end
  end

  always_comb begin
    stb.conv        = convStart;
    stb.asyncBefore = asyncSeen;
    stb.gain        = gainReg;
    stb.code        = codeReg;
  end

endmodule

// File: rtl/acqSeqPath.sv
module acqSeqPath
  import acqSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  output logic              convDone,
  output logic [2:0]        ch1Src,
  output logic [2:0]        ch2Src,
  output logic [2:0]        ch3Src,
  output logic [GAIN_W-1:0] gainCh1,
  output logic [GAIN_W-1:0] gainCh2,
  output logic [GAIN_W-1:0] gainCh3,
  output logic [2:0]        syncSampleStb,
  output logic [1:0]        deferStb,
  output logic [1:0]        asyncMuxSel,
  output logic [2:0]        undefFlag
);

  srcSel_e   src1Q, src2Q, src3Q, nSrc1, nSrc2, nSrc3;
  asyncMux_e asyncQ, nAsync;
  logic [1:0]        deferValid, nValid;
  logic [2:0]        nSamp, nUndef;
  logic [1:0]        nDefer;
  logic [GAIN_W-1:0] nGain3;
  logic              asyncBad;

  assign asyncBad = (asyncQ == AMUX_OPEN) || !stb.asyncBefore;

  always_comb begin
    nSrc1  = SRC_NONE;
    nSrc2  = SRC_NONE;
    nSrc3  = SRC_IN4;
    nSamp  = 3'b100;
    nDefer = 2'b00;
    nUndef = 3'b000;
    nAsync = asyncQ;
    nValid = deferValid;
    nGain3 = GAIN_UNITY;
    case (stb.code)
      3'd7: begin
        nSrc1 = SRC_IN1; nSrc2 = SRC_IN1; nSrc3 = SRC_IN1;
        nSamp  = 3'b111;
        nGain3 = stb.gain;
      end
      3'd6, 3'd5, 3'd4: begin
        nSrc1 = SRC_IN2; nSrc2 = SRC_IN2; nSrc3 = SRC_IN2;
        nSamp  = 3'b111;
        nDefer = 2'b11;
        nValid = 2'b11;
        case (stb.code)
          3'd4:    nAsync = AMUX_OPEN;
          3'd5:    nAsync = AMUX_IN3;
          default: nAsync = AMUX_IN2;
        endcase
      end
      3'd3: begin
        nSrc1 = SRC_IN3_DEFER; nSrc2 = SRC_IN3_DEFER; nSrc3 = SRC_IN3;
        nUndef = {1'b0, ~deferValid[1], ~deferValid[0]};
      end
      3'd2: begin
        nSrc1 = SRC_IN3; nSrc2 = SRC_IN3; nSrc3 = SRC_IN3;
        nSamp     = 3'b111;
        nDefer    = 2'b01;
        nValid[0] = 1'b1;
      end
      3'd1: begin
        nSrc1 = SRC_ASYNC; nSrc2 = SRC_ASYNC;
        nUndef = {1'b0, asyncBad, asyncBad};
      end
      default: nUndef = 3'b011;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convDone      <= 1'b0;
      src1Q         <= SRC_NONE;
      src2Q         <= SRC_NONE;
      src3Q         <= SRC_NONE;
      gainCh1       <= '0;
      gainCh2       <= '0;
      gainCh3       <= '0;
      syncSampleStb <= '0;
      deferStb      <= '0;
      undefFlag     <= '0;
      asyncQ        <= AMUX_OPEN;
      deferValid    <= '0;
    end else begin
      convDone <= stb.conv;
      if (stb.conv) begin
        src1Q         <= nSrc1;
        src2Q         <= nSrc2;
        src3Q         <= nSrc3;
        gainCh1       <= stb.gain;
        gainCh2       <= stb.gain;
        gainCh3       <= nGain3;
        syncSampleStb <= nSamp;
        deferStb      <= nDefer;
        undefFlag     <= nUndef;
        asyncQ        <= nAsync;
        deferValid    <= nValid;
      end else begin
        syncSampleStb <= '0;
        deferStb      <= '0;
      end
    end
  end

  assign ch1Src      = src1Q;
  assign ch2Src      = src2Q;
  assign ch3Src      = src3Q;
  assign asyncMuxSel = asyncQ;

endmodule

// File: rtl/acqSelectSeq.sv
module acqSelectSeq
  import acqSeqPkg::*;
#(
  parameter int GAIN_LSB = 8,
  parameter int SEL_LSB  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIn,
  input  logic       shiftEn,
  input  logic       loadStb,
  input  logic       convStart,
  input  logic       asyncHoldN,
  output logic       convDone,
  output logic [2:0] ch1Src,
  output logic [2:0] ch2Src,
  output logic [2:0] ch3Src,
  output logic [1:0] gainCh1,
  output logic [1:0] gainCh2,
  output logic [1:0] gainCh3,
  output logic [2:0] syncSampleStb,
  output logic [1:0] deferStb,
  output logic [1:0] asyncMuxSel,
  output logic [2:0] undefFlag
);

  ctrlStb_t stb;

  acqSeqCtrl #(.GAIN_LSB(GAIN_LSB), .SEL_LSB(SEL_LSB)) uCtrl (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftEn(shiftEn),
    .loadStb(loadStb), .convStart(convStart), .asyncHoldN(asyncHoldN),
    .stb(stb)
  );

  acqSeqPath uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .convDone(convDone), .ch1Src(ch1Src), .ch2Src(ch2Src), .ch3Src(ch3Src),
    .gainCh1(gainCh1), .gainCh2(gainCh2), .gainCh3(gainCh3),
    .syncSampleStb(syncSampleStb), .deferStb(deferStb),
    .asyncMuxSel(asyncMuxSel), .undefFlag(undefFlag)
  );

endmodule

// File: rtl/acqSelectSeqChk.sv
module acqSelectSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       convStart,
  input logic       convDone,
  input logic [2:0] ch1Src,
  input logic [2:0] ch3Src,
  input logic [1:0] gainCh3,
  input logic [2:0] syncSampleStb,
  input logic [1:0] deferStb,
  input logic [1:0] asyncMuxSel,
  input logic [2:0] undefFlag
);

  p_done_follows_conv_r11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> convDone);

  p_done_needs_conv_r11: assert property (@(posedge clk) disable iff (!rstN)
    !convStart |=> !convDone);

  p_strobes_in_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((|syncSampleStb) || (|deferStb)) |-> convDone);

  p_amux_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !convStart |=> $stable(asyncMuxSel));

  p_amux_change_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (asyncMuxSel != $past(asyncMuxSel)) |-> (convDone && ch1Src == 3'd2));

  p_defer_with_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|deferStb) |-> syncSampleStb[0]);

  p_ch3_defined_r9: assert property (@(posedge clk) disable iff (!rstN)
    !undefFlag[2]);

  p_none_src_undef_r9: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && ch1Src == 3'd0) |-> (undefFlag[1:0] == 2'b11));

  p_ch3_unity_r10: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && ch3Src != 3'd1) |-> (gainCh3 == 2'd3));

endmodule

bind acqSelectSeq acqSelectSeqChk chk (.*);

// File: tb/tb_acqSelectSeq.sv
module tb_acqSelectSeq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, shiftEn = 1'b0, loadStb = 1'b0, convStart = 1'b0;
  logic asyncHoldN = 1'b1;
  logic       convDone;
  logic [2:0] ch1Src, ch2Src, ch3Src;
  logic [1:0] gainCh1, gainCh2, gainCh3;
  logic [2:0] syncSampleStb;
  logic [1:0] deferStb;
  logic [1:0] asyncMuxSel;
  logic [2:0] undefFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of persistent state
  bit [1:0] mAsync = 2'd0;
  bit [1:0] mValid = 2'd0;
  bit       mSeen  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acqSelectSeq dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftEn(shiftEn),
    .loadStb(loadStb), .convStart(convStart), .asyncHoldN(asyncHoldN),
    .convDone(convDone), .ch1Src(ch1Src), .ch2Src(ch2Src), .ch3Src(ch3Src),
    .gainCh1(gainCh1), .gainCh2(gainCh2), .gainCh3(gainCh3),
    .syncSampleStb(syncSampleStb), .deferStb(deferStb),
    .asyncMuxSel(asyncMuxSel), .undefFlag(undefFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  task automatic loadWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      serIn = w[i];
      shiftEn = 1'b1;
      @(negedge clk);
    end
    shiftEn = 1'b0;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic asyncPulse();
    asyncHoldN = 1'b0;
    @(negedge clk);
    asyncHoldN = 1'b1;
    @(negedge clk);
    mSeen = 1'b1;
  endtask

  function automatic logic [15:0] mkWord(input logic [2:0] sel, input logic [1:0] gain,
                                         input logic [15:0] junk);
    logic [15:0] w = junk;
    w[12:10] = sel;
    w[9:8]   = gain;
    return w;
  endfunction

  // mode: 0 no async fall, 1 fall before convert, 2 fall on the convert edge
  task automatic runConv(input logic [2:0] sel, input logic [1:0] gain,
                         input int mode, input logic [15:0] junk);
    int eS1, eS2, eS3, eSamp, eDef, eUnd, eG3, eAm;
    bit bad;
    loadWord(mkWord(sel, gain, junk));
    if (mode == 1) asyncPulse();
    eAm = mAsync; eSamp = 3'b100; eDef = 0; eUnd = 0; eG3 = 3;
    case (sel)
      3'd7: begin eS1 = 1; eS2 = 1; eS3 = 1; eSamp = 7; eG3 = gain; end
      3'd4, 3'd5, 3'd6: begin
        eS1 = 2; eS2 = 2; eS3 = 2; eSamp = 7; eDef = 3;
        eAm = (sel == 3'd4) ? 0 : (sel == 3'd5) ? 1 : 2;
      end
      3'd3: begin
        eS1 = 4; eS2 = 4; eS3 = 3;
        eUnd = {1'b0, ~mValid[1], ~mValid[0]};
      end
      3'd2: begin eS1 = 3; eS2 = 3; eS3 = 3; eSamp = 7; eDef = 1; end
      3'd1: begin
        eS1 = 5; eS2 = 5; eS3 = 6;
        bad = (mAsync == 2'd0) || !mSeen;
        eUnd = bad ? 3 : 0;
      end
      default: begin eS1 = 0; eS2 = 0; eS3 = 6; eUnd = 3; end
    endcase
    convStart = 1'b1;
    if (mode == 2) asyncHoldN = 1'b0;
    @(negedge clk);
    convStart = 1'b0;
    asyncHoldN = 1'b1;
    chk("R11 convDone", convDone, 1);
    chk("R3 ch1Src", ch1Src, eS1);
    chk("R3 ch2Src", ch2Src, eS2);
    chk("R3 ch3Src", ch3Src, eS3);
    chk("R4 syncSampleStb", syncSampleStb, eSamp);
    chk("R7 deferStb", deferStb, eDef);
    chk("R8 undefFlag", undefFlag, eUnd);
    chk("R5 asyncMuxSel", asyncMuxSel, eAm);
    chk("R10 gainCh1", gainCh1, gain);
    chk("R10 gainCh2", gainCh2, gain);
    chk("R10 gainCh3", gainCh3, eG3);
    // update model
    mAsync = eAm[1:0];
    if (eDef == 3) mValid = 2'b11;
    if (eDef == 1) mValid[0] = 1'b1;
    mSeen = (mode == 2);
    @(negedge clk);
    chk("R11 convDone drops", convDone, 0);
    chk("R11 strobes drop", {syncSampleStb, deferStb}, 0);
    chk("R11 ch1Src holds", ch1Src, eS1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 convDone", convDone, 0);
    chk("R2 srcs", {ch1Src, ch2Src, ch3Src}, 0);
    chk("R2 gains", {gainCh1, gainCh2, gainCh3}, 0);
    chk("R2 strobes", {syncSampleStb, deferStb}, 0);
    chk("R2 asyncMuxSel", asyncMuxSel, 0);
    chk("R2 undefFlag", undefFlag, 0);

    // R2 R6: no capture yet -> both undefined
    runConv(3'd3, 2'd1, 0, 16'hFFFF);
    chk("R6 undef after reset", undefFlag, 3);
    // R8: mux open, no fall
    runConv(3'd1, 2'd0, 0, 16'h0000);
    // R7 then R6: only ch1 captured
    runConv(3'd2, 2'd2, 0, 16'hA5A5);
    runConv(3'd3, 2'd2, 0, 16'h5A5A);
    chk("R6 ch2 undef only", undefFlag, 3'b010);
    // R5 select input 3, then async before convert -> valid
    runConv(3'd5, 2'd3, 0, 16'h1234);
    runConv(3'd1, 2'd1, 1, 16'h0000);
    chk("R8 valid async", undefFlag, 0);
    // R8 same-edge fall: undefined now, valid next
    runConv(3'd1, 2'd1, 2, 16'hFFFF);
    chk("R8 same edge undef", undefFlag, 3);
    runConv(3'd1, 2'd1, 0, 16'h0F0F);
    chk("R8 carried fall valid", undefFlag, 0);
    // R5 select input 2 then idle hold and load without convert
    runConv(3'd6, 2'd0, 0, 16'hFFFF);
    loadWord(mkWord(3'd4, 2'd1, 16'h0000));
    repeat (4) @(negedge clk);
    chk("R5 hold without convert", asyncMuxSel, 2);
    chk("R11 src holds without convert", ch1Src, 2);
    // R5 open, R8 open mux undefined even with fall
    runConv(3'd4, 2'd0, 0, 16'h0000);
    runConv(3'd1, 2'd0, 1, 16'h0000);
    chk("R8 open mux undef", undefFlag, 3);
    // R9 and R3 R10
    runConv(3'd0, 2'd2, 0, 16'hE3FF);
    runConv(3'd7, 2'd2, 0, 16'h0000);
    chk("R10 ch3 follows gain on 7", gainCh3, 2);
    // R1 junk bits ignored
    runConv(3'd7, 2'd1, 0, 16'hE0FF);

    // random mix
    void'($urandom(32'd1357));
    for (int i = 0; i < 200; i++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      logic [1:0] g = 2'($urandom_range(0, 3));
      int md = $urandom_range(0, 2);
      runConv(s, g, md, 16'($urandom));
    end

    done = 1'b1;
    summary();
  end

endmodule